// File: doc/BRIEF.md
# Flash Controller Status and Interrupt Unit

This block holds the status and interrupt state of a NAND flash controller. It watches the ready/busy lines of two flash devices and the idle/busy state of the controller's command sequencer. It also keeps a one-word command slot that software fills and the sequencer empties. Three sticky event flags record a busy-to-ready transition, a finished command and a finished DMA transfer. Each flag has its own enable bit, and the enabled flags together drive one registered interrupt line.

Software uses a simple register port. A status word at offset 0x04 can be read, and its event bits are cleared by writing 1. An enable word at offset 0x08 can be read and written. The sequencer and the DMA engine appear only as single-cycle pulses: command latched, command started, command finished and DMA finished. When a new command starts, the command-done and DMA-done flags clear by themselves. The busy-to-ready flag clears only when software writes 1 to it.

Top module: `nfc_status_irq`

## Requirements
- R1: Status bit 0 (busy-to-ready) sets on a low-to-high transition of ready/busy line 0 after its two-flop synchronizer. The flag is visible on the third rising edge after the line changes. It clears only when 1 is written to bit 0 of the word at 0x04.
- R2: Status bit 1 (command done) sets one cycle after a command-finish pulse. It clears on a write of 1 to bit 1 at 0x04, or on a command-start pulse.
- R3: Status bit 2 (DMA done) sets one cycle after a DMA-finish pulse. It clears on a write of 1 to bit 2 at 0x04, or on a command-start pulse.
- R4: Status bit 3 reads 1 while the command slot holds a word. A write into the empty slot stores the data and sets the bit on the next cycle. A sequencer latch pulse empties the slot.
- R5: Status bit 4 reads 1 from the cycle after a command-start pulse until the cycle after a command-finish pulse. If both pulses arrive in the same cycle, the bit is 1.
- R6: Status bits 8 and 9 show ready/busy lines 0 and 1 (1 = ready) after two synchronizer flops. Bits 7:5 and 31:10 read 0.
- R7: The enable word at 0x08 resets to 0. Bit 0 enables busy-to-ready, bit 1 enables command done and bit 2 enables DMA done. Bits 31:3 read 0. Any other address reads 0, and writes to it change nothing.
- R8: The interrupt output is 1 exactly one cycle after any flag and its enable bit are both 1.
- R9: A command write while the slot is full is dropped and the held word stays unchanged. An overflow output pulses for one cycle on the following cycle.
- R10: When a set event and a clear for the same flag fall in the same cycle, the flag ends up set.
- R11: After reset, all status flags, enable bits, the interrupt and the overflow output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rb_line_i | input | 2 | Asynchronous ready/busy lines, 1 = ready |
| cmd_wr_i | input | 1 | Software command write strobe |
| cmd_data_i | input | 32 | Command word to store |
| cmd_latch_i | input | 1 | Sequencer takes the held command |
| cmd_start_i | input | 1 | Sequencer begins a command |
| cmd_done_i | input | 1 | Sequencer finished a command or batch |
| dma_done_i | input | 1 | DMA transfer finished |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| cmd_word_o | output | 32 | Word held in the command slot |
| irq_o | output | 1 | Combined interrupt |
| ovf_o | output | 1 | One-cycle pulse on a dropped command write |

## Verification
Two collisions matter most. The first is an event flag being set in the same cycle that a write-1 or a command start clears it. The second is a command write arriving while the slot is full, in the same cycle as a sequencer latch. Directed steps force each collision once. Random pulses at high density then repeat them many times. In every case, the reference model computed in the bench decides the expected flag, slot state, held word and overflow pulse.

// File: rtl/nfc_stat_pkg.sv
package nfc_stat_pkg;
    localparam logic [7:0] STAT_OFS = 8'h04;
    localparam logic [7:0] IEN_OFS  = 8'h08;
    localparam int NEV     = 3;
    localparam int EV_B2R  = 0;
    localparam int EV_CMD  = 1;
    localparam int EV_DMA  = 2;
    localparam int BIT_FULL = 3;
    localparam int BIT_BUSY = 4;
    localparam int BIT_RB0  = 8;
    // flags that self-clear when a new command starts
    localparam logic [NEV-1:0] AUTO_CLR_MASK = 3'b110;
endpackage

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], line_i};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh   <= '1;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.sh[STAGES-1];
    assign rise_o  = st_q.sh[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/nfc_event_flags.sv
module nfc_event_flags
    import nfc_stat_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] set_i,
    input  logic [NEV-1:0] w1c_i,
    input  logic           auto_clr_i,
    output logic [NEV-1:0] flags_o
);
    logic [NEV-1:0] flags_d, flags_q;
    logic [NEV-1:0] clr_d;

    always_comb begin
        clr_d   = w1c_i | (auto_clr_i ? AUTO_CLR_MASK : '0);
        // set has priority over any clear
        flags_d = set_i | (flags_q & ~clr_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/nfc_cmd_slot.sv
module nfc_cmd_slot #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] data_i,
    input  logic          latch_i,
    output logic          full_o,
    output logic [DW-1:0] word_o,
    output logic          ovf_o
);
    typedef struct packed {
        logic          full;
        logic [DW-1:0] word;
        logic          ovf;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = wr_i & st_q.full;
        if (!st_q.full) begin
            if (wr_i) begin
                st_d.full = 1'b1;
                st_d.word = data_i;
            end
        end else if (latch_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_o = st_q.full;
    assign word_o = st_q.word;
    assign ovf_o  = st_q.ovf;
endmodule

// File: rtl/nfc_status_irq.sv
module nfc_status_irq
    import nfc_stat_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 8,
    parameter int RB_LINES    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int B2R_SEL     = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RB_LINES-1:0] rb_line_i,
    input  logic                cmd_wr_i,
    input  logic [DW-1:0]       cmd_data_i,
    input  logic                cmd_latch_i,
    input  logic                cmd_start_i,
    input  logic                cmd_done_i,
    input  logic                dma_done_i,
    input  logic                reg_wr_i,
    input  logic [AW-1:0]       reg_addr_i,
    input  logic [DW-1:0]       reg_wdata_i,
    output logic [DW-1:0]       reg_rdata_o,
    output logic [DW-1:0]       cmd_word_o,
    output logic                irq_o,
    output logic                ovf_o
);
    localparam logic [RB_LINES-1:0] SEL_MASK = RB_LINES'(1) << B2R_SEL;

    typedef struct packed {
        logic [NEV-1:0] ien;
        logic           busy;
        logic           irq;
    } top_st_t;

    top_st_t        st_d, st_q;
    logic [RB_LINES-1:0] rb_lvl, rb_rise;
    logic [NEV-1:0] ev_set, ev_w1c, flags_q;
    logic           slot_full;
    logic           stat_sel, ien_sel;
    logic [DW-1:0]  stat_word;
    logic           unused_bits;

    for (genvar g = 0; g < RB_LINES; g++) begin : g_rb
        nfc_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (rb_line_i[g]),
            .level_o (rb_lvl[g]),
            .rise_o  (rb_rise[g])
        );
    end

    assign stat_sel = (reg_addr_i == AW'(STAT_OFS));
    assign ien_sel  = (reg_addr_i == AW'(IEN_OFS));

    always_comb begin
        ev_set         = '0;
        ev_set[EV_B2R] = |(rb_rise & SEL_MASK);
        ev_set[EV_CMD] = cmd_done_i;
        ev_set[EV_DMA] = dma_done_i;
        ev_w1c         = (reg_wr_i && stat_sel) ? reg_wdata_i[NEV-1:0] : '0;
    end

    nfc_event_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (ev_set),
        .w1c_i      (ev_w1c),
        .auto_clr_i (cmd_start_i),
        .flags_o    (flags_q)
    );

    nfc_cmd_slot #(.DW(DW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cmd_wr_i),
        .data_i  (cmd_data_i),
        .latch_i (cmd_latch_i),
        .full_o  (slot_full),
        .word_o  (cmd_word_o),
        .ovf_o   (ovf_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.busy = cmd_start_i | (st_q.busy & ~cmd_done_i);
        st_d.irq  = |(flags_q & st_q.ien);
        if (reg_wr_i && ien_sel) st_d.ien = reg_wdata_i[NEV-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat_word                          = '0;
        stat_word[NEV-1:0]                 = flags_q;
        stat_word[BIT_FULL]                = slot_full;
        stat_word[BIT_BUSY]                = st_q.busy;
        stat_word[BIT_RB0 +: RB_LINES]     = rb_lvl;
        if (stat_sel)     reg_rdata_o = stat_word;
        else if (ien_sel) reg_rdata_o = DW'(st_q.ien);
        else              reg_rdata_o = '0;
    end

    assign irq_o       = st_q.irq;
    assign unused_bits = ^{reg_wdata_i[DW-1:NEV], rb_rise & ~SEL_MASK};
endmodule

module nfc_status_irq_chk
    import nfc_stat_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [NEV-1:0] flags,
    input logic [NEV-1:0] en,
    input logic           full,
    input logic           busy,
    input logic           cmd_wr_i,
    input logic           cmd_start_i,
    input logic           cmd_done_i,
    input logic           reg_wr_i,
    input logic [7:0]     reg_addr_i,
    input logic [31:0]    reg_wdata_i,
    input logic [31:0]    cmd_word_o,
    input logic           irq_o,
    input logic           ovf_o
);
    assert_b2r_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[EV_B2R] && !(reg_wr_i && reg_addr_i == STAT_OFS && reg_wdata_i[EV_B2R])) |=> flags[EV_B2R]);
    assert_cmd_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_i |=> flags[EV_CMD]);
    assert_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && !full) |=> full);
    assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_i |=> busy);
    assert_irq_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & en)) |=> irq_o);
    assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flags & en)) |=> !irq_o);
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(cmd_wr_i && full));
    assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && full) |=> $stable(cmd_word_o));
endmodule

bind nfc_status_irq nfc_status_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flags       (flags_q),
    .en          (st_q.ien),
    .full        (slot_full),
    .busy        (st_q.busy),
    .cmd_wr_i    (cmd_wr_i),
    .cmd_start_i (cmd_start_i),
    .cmd_done_i  (cmd_done_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .cmd_word_o  (cmd_word_o),
    .irq_o       (irq_o),
    .ovf_o       (ovf_o)
);

// File: tb/nfc_status_irq_bench.sv
`timescale 1ns/100ps
module nfc_status_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rb_line = 2'b11;
    logic        cmd_wr = 0, cmd_latch = 0, cmd_start = 0, cmd_done = 0, dma_done = 0, reg_wr = 0;
    logic [31:0] cmd_data = 0, reg_wdata = 0;
    logic [7:0]  reg_addr = 8'h04;
    logic [31:0] reg_rdata, cmd_word;
    logic        irq, ovf;

    int vectors = 0, errors = 0;

    // reference model state
    logic [1:0]  m_s1 = 2'b11, m_s2 = 2'b11;
    logic        m_prev = 1'b1;
    logic [2:0]  m_flags = 0, m_en = 0;
    logic        m_busy = 0, m_full = 0, m_ovf = 0, m_irq = 0;
    logic [31:0] m_word = 0;

    always #2 clk = ~clk;

    nfc_status_irq u_nfc_status_irq (
        .clk(clk), .rst_n(rst_n), .rb_line_i(rb_line),
        .cmd_wr_i(cmd_wr), .cmd_data_i(cmd_data), .cmd_latch_i(cmd_latch),
        .cmd_start_i(cmd_start), .cmd_done_i(cmd_done), .dma_done_i(dma_done),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .cmd_word_o(cmd_word), .irq_o(irq), .ovf_o(ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[2:0] = m_flags; s[3] = m_full; s[4] = m_busy; s[9:8] = m_s2;
        return s;
    endfunction

    task automatic check_all();
        logic [31:0] st;
        reg_addr = 8'h04; #0.5;
        st = reg_rdata;
        chk("R1 b2r flag", 32'(st[0]), 32'(m_flags[0]));
        chk("R2 cmd flag", 32'(st[1]), 32'(m_flags[1]));
        chk("R3 dma flag", 32'(st[2]), 32'(m_flags[2]));
        chk("R4 slot full", 32'(st[3]), 32'(m_full));
        chk("R5 busy", 32'(st[4]), 32'(m_busy));
        chk("R6 status word", st, exp_status());
        reg_addr = 8'h08; #0.5;
        chk("R7 enable word", reg_rdata, 32'(m_en));
        reg_addr = 8'h10; #0.5;
        chk("R7 unmapped read", reg_rdata, 32'h0);
        chk("R8 irq", 32'(irq), 32'(m_irq));
        chk("R9 ovf", 32'(ovf), 32'(m_ovf));
        chk("R9 held word", cmd_word, m_word);
    endtask

    task automatic model_clock();
        logic [2:0] w1c, nf;
        logic rise;
        rise = m_s2[0] & ~m_prev;
        w1c  = (reg_wr && reg_addr == 8'h04) ? reg_wdata[2:0] : 3'b0;
        nf[0] = rise     | (m_flags[0] & ~w1c[0]);
        nf[1] = cmd_done | (m_flags[1] & ~(w1c[1] | cmd_start));
        nf[2] = dma_done | (m_flags[2] & ~(w1c[2] | cmd_start));
        m_irq = |(m_flags & m_en);
        if (reg_wr && reg_addr == 8'h08) m_en = reg_wdata[2:0];
        m_busy = cmd_start | (m_busy & ~cmd_done);
        m_ovf  = cmd_wr & m_full;
        if (!m_full) begin
            if (cmd_wr) begin m_full = 1'b1; m_word = cmd_data; end
        end else if (cmd_latch) m_full = 1'b0;
        m_prev = m_s2[0]; m_s2 = m_s1; m_s1 = rb_line;
        m_flags = nf;
    endtask

    // called at a negedge: drive, clock once, then check
    task automatic step(input logic [1:0] rb, input logic wr, input logic [31:0] dat,
                        input logic lat, input logic st, input logic dn, input logic dm,
                        input logic rw, input logic [7:0] ad, input logic [31:0] wd);
        rb_line = rb; cmd_wr = wr; cmd_data = dat; cmd_latch = lat;
        cmd_start = st; cmd_done = dn; dma_done = dm;
        reg_wr = rw; reg_addr = ad; reg_wdata = wd;
        @(posedge clk);
        model_clock();
        @(negedge clk);
        reg_wr = 0; cmd_wr = 0; cmd_latch = 0; cmd_start = 0; cmd_done = 0; dma_done = 0;
        check_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            step(rb_line, 0, 0, 0, 0, 0, 0, 0, 8'h10, 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check_all();                         // R11 reset state
        chk("R11 irq at reset", 32'(irq), 0);
        rst_n = 1'b1;
        // R6/R1: busy then ready on line 0
        step(2'b10, 0, 0, 0, 0, 0, 0, 0, 8'h10, 0);
        idle(4);
        step(2'b11, 0, 0, 0, 0, 0, 0, 0, 8'h10, 0);
        idle(4);
        // R7: enable all; R8 irq follows
        step(2'b11, 0, 0, 0, 0, 0, 0, 1, 8'h08, 32'hffff_ffff);
        idle(2);
        // R10: cmd_done with write-1 to bit 1 in the same cycle
        step(2'b11, 0, 0, 0, 0, 1, 0, 1, 8'h04, 32'h7);
        // R10/R5: start with done and dma in same cycle
        step(2'b11, 0, 0, 0, 1, 1, 1, 0, 8'h10, 0);
        // R2/R3: start clears both
        step(2'b11, 0, 0, 0, 1, 0, 0, 0, 8'h10, 0);
        // R4/R9: fill, write while full with a latch
        step(2'b11, 1, 32'hcafe_0001, 0, 0, 0, 0, 0, 8'h10, 0);
        step(2'b11, 1, 32'hdead_0002, 1, 0, 0, 0, 0, 8'h10, 0);
        step(2'b11, 1, 32'hbeef_0003, 0, 0, 0, 0, 0, 8'h10, 0);
        step(2'b11, 1, 32'h1111_0004, 0, 0, 0, 0, 0, 8'h10, 0);
        // R7: write to an unmapped offset has no effect
        step(2'b11, 0, 0, 0, 0, 0, 0, 1, 8'h0c, 32'hffff_ffff);
        idle(1);
        // random phase
        for (int i = 0; i < 6000; i++) begin
            logic [1:0] rb = rb_line;
            logic [7:0] ad;
            case ($urandom % 3)
                0: ad = 8'h04;
                1: ad = 8'h08;
                default: ad = 8'h10;
            endcase
            if ($urandom % 6 == 0) rb[0] = ~rb[0];
            if ($urandom % 6 == 0) rb[1] = ~rb[1];
            step(rb, ($urandom % 4) == 0, $urandom, ($urandom % 4) == 0,
                 ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                 ($urandom % 4) == 0, ad, $urandom);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule